// File: doc/BRIEF.md
# Two-Stage Tick Divider with Decimal Digit Counter

This block turns a fast system clock (100 MHz by default) into slow, human-visible timing. A first divider stage makes a 1 kHz square wave, and a second stage, driven by the first stage's toggle events, makes a 1 Hz square wave suitable for blinking an LED. Each rising edge of the 1 Hz wave advances a single decimal digit that runs from zero up to nine and then starts again at zero. The digit is meant to drive four LEDs.

Every flop runs on the one fast clock. The stages are linked by single-cycle enable pulses, not by derived clocks, so timing closure and reset behave as they do for any other logic on that clock. Both half-periods are parameters: the defaults give 1 kHz and 1 Hz from 100 MHz, and a testbench can shrink them to reach every cadence and the digit wrap in a few hundred cycles. A synchronous reset puts every counter and output back at zero.

Top module: `slow_tick_chain`

## Requirements
- R1: `fast_wave_o` is 0 after reset and inverts once every `FAST_HALF` clock cycles (default 50,000, giving a 1 kHz square wave from 100 MHz). Its first inversion occurs on the `FAST_HALF`-th rising clock edge after reset is released.
- R2: `slow_wave_o` is 0 after reset and inverts once every `SLOW_HALF` inversions of `fast_wave_o` (default 1,000, giving a 1 Hz square wave). That is once every `FAST_HALF*SLOW_HALF` clock cycles.
- R3: `digit_o` is an unsigned binary value. It increases by one on the same clock edge at which `slow_wave_o` goes from 0 to 1, and holds its value on every other edge.
- R4: `digit_o` never exceeds 9. The increment that would follow 9 yields 0.
- R5: When `rst` is high at a rising clock edge, both divider counters, `fast_wave_o`, `slow_wave_o` and `digit_o` are all zero after that edge. The cadence then restarts from zero.
- R6: `slow_wave_o` changes only on an edge at which `fast_wave_o` also inverts. Its inversions fall exactly on multiples of `FAST_HALF*SLOW_HALF` cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| fast_wave_o | output | 1 | Square wave from the first stage (1 kHz by default) |
| slow_wave_o | output | 1 | Square wave from the second stage (1 Hz by default), for an LED |
| digit_o | output | 4 | Decimal digit 0..9 in binary, for LEDs |

## Verification
The hardest situation to reach from the ports is the digit rolling over from nine to zero. At the default ratios this takes ten full seconds of slow-wave periods, which is hundreds of millions of cycles. The bench elaborates the block with half-periods of 4 and 3, so one slow toggle takes 12 cycles and the wrap arrives within about 230 cycles. It checks every output on every cycle against a closed-form model built on the count of edges since reset. A reset is also applied in the middle of a slow half-period to show that the cadence restarts cleanly from zero.

// File: rtl/tick_chain_pkg.sv
`timescale 1ns/1ps
package tick_chain_pkg;
  // Modulo counter step: returns zero after reaching last, else cur+1.
  function automatic int unsigned wrap_next(input int unsigned cur,
                                            input int unsigned last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

  localparam logic [3:0] DIGIT_TOP = 4'd9;

  // Decimal digit step: 0..9 then back to 0.
  function automatic logic [3:0] decade_next(input logic [3:0] cur);
    return (cur >= DIGIT_TOP) ? 4'd0 : cur + 4'd1;
  endfunction
endpackage

// File: rtl/pace_divider.sv
`timescale 1ns/1ps
module pace_divider
  import tick_chain_pkg::*;
#(
  parameter int unsigned HALF = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic wave_o,
  output logic tick_o,
  output logic rise_o
);
  localparam int unsigned CW   = (HALF < 2) ? 1 : $clog2(HALF);
  localparam int unsigned LAST = HALF - 1;

  logic [CW-1:0] cnt_q;
  logic          wave_q;

  assign tick_o = step_i && (32'(cnt_q) == LAST);
  assign rise_o = tick_o && !wave_q;
  assign wave_o = wave_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (step_i) begin
      cnt_q <= CW'(wrap_next(32'(cnt_q), LAST));
      if (tick_o) wave_q <= !wave_q;
    end
  end
endmodule

// File: rtl/decade_counter.sv
`timescale 1ns/1ps
module decade_counter
  import tick_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  output logic [3:0] digit_o
);
  logic [3:0] digit_q;

  always_ff @(posedge clk) begin
    if (rst)         digit_q <= 4'd0;
    else if (step_i) digit_q <= decade_next(digit_q);
  end

  assign digit_o = digit_q;
endmodule

// File: rtl/slow_tick_chain.sv
`timescale 1ns/1ps
module slow_tick_chain #(
  parameter int unsigned FAST_HALF = 50000,
  parameter int unsigned SLOW_HALF = 1000
) (
  input  logic       clk,
  input  logic       rst,
  output logic       fast_wave_o,
  output logic       slow_wave_o,
  output logic [3:0] digit_o
);
  // Internal events, named so the checker can observe them.
  logic fast_tick, fast_rise;
  logic slow_tick, slow_rise;

  pace_divider #(.HALF(FAST_HALF)) u_fast (
    .clk(clk), .rst(rst), .step_i(1'b1),
    .wave_o(fast_wave_o), .tick_o(fast_tick), .rise_o(fast_rise)
  );

  pace_divider #(.HALF(SLOW_HALF)) u_slow (
    .clk(clk), .rst(rst), .step_i(fast_tick),
    .wave_o(slow_wave_o), .tick_o(slow_tick), .rise_o(slow_rise)
  );

  decade_counter u_digit (
    .clk(clk), .rst(rst), .step_i(slow_rise), .digit_o(digit_o)
  );
endmodule

module slow_tick_chain_chk (
  input logic       clk,
  input logic       rst,
  input logic       fast_tick,
  input logic       fast_rise,
  input logic       slow_tick,
  input logic       slow_rise,
  input logic       fast_wave_o,
  input logic       slow_wave_o,
  input logic [3:0] digit_o
);
  // R1
  fast_flip_chk: assert property (@(posedge clk) disable iff (rst)
    fast_tick |=> (fast_wave_o != $past(fast_wave_o)));
  // R1
  fast_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fast_tick |=> $stable(fast_wave_o));
  // R1
  fast_rise_chk: assert property (@(posedge clk) disable iff (rst)
    fast_rise |=> fast_wave_o);
  // R6
  slow_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !fast_tick |=> $stable(slow_wave_o));
  // R2
  slow_flip_chk: assert property (@(posedge clk) disable iff (rst)
    slow_tick |=> (slow_wave_o != $past(slow_wave_o)));
  // R3
  digit_step_chk: assert property (@(posedge clk) disable iff (rst)
    slow_rise |=> (digit_o == (($past(digit_o) == 4'd9) ? 4'd0 : $past(digit_o) + 4'd1)));
  // R3
  digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !slow_rise |=> $stable(digit_o));
  // R4
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    digit_o <= 4'd9);
  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (digit_o == 4'd0 && !fast_wave_o && !slow_wave_o));
endmodule

bind slow_tick_chain slow_tick_chain_chk u_chk (
  .clk(clk), .rst(rst),
  .fast_tick(fast_tick), .fast_rise(fast_rise),
  .slow_tick(slow_tick), .slow_rise(slow_rise),
  .fast_wave_o(fast_wave_o), .slow_wave_o(slow_wave_o), .digit_o(digit_o)
);

// File: tb/slow_tick_chain_tb_top.sv
`timescale 1ns/1ps
module slow_tick_chain_tb_top;
  localparam int unsigned F = 4;
  localparam int unsigned S = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fast_wave, slow_wave;
  logic [3:0] digit;

  int unsigned n = 0;        // rising edges since reset released
  int          compared = 0;
  int          mismatched = 0;
  bit          saw_wrap = 1'b0;

  always #2 clk = ~clk;      // 250 MHz

  slow_tick_chain #(.FAST_HALF(F), .SLOW_HALF(S)) dut_i (
    .clk(clk), .rst(rst),
    .fast_wave_o(fast_wave), .slow_wave_o(slow_wave), .digit_o(digit)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  // One clock edge; the edge count is tracked from the reset input alone.
  task automatic step();
    @(posedge clk);
    #1;
    if (rst) n = 0; else n++;
  endtask

  task automatic check_model();
    int unsigned t;
    t = n / (F * S);
    check("R1 fast wave", fast_wave, (n / F) % 2);
    check("R2/R6 slow wave", slow_wave, t % 2);
    check("R3 digit", digit, ((t + 1) / 2) % 10);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) step();
    // R5
    check("R5 fast after reset", fast_wave, 0);
    check("R5 slow after reset", slow_wave, 0);
    check("R5 digit after reset", digit, 0);
  endtask

  task automatic t_cadence();
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 3 * F * S; i++) begin
      step();
      check_model();
      // R1: first toggle exactly on edge F
      if (n == F - 1) check("R1 first toggle not early", fast_wave, 0);
      if (n == F)     check("R1 first toggle", fast_wave, 1);
      // R6: slow wave flips on edge F*S
      if (n == F * S) check("R6 slow first toggle", slow_wave, 1);
    end
  endtask

  task automatic t_wrap();
    logic [3:0] prev;
    prev = digit;
    for (int i = 0; i < 22 * F * S; i++) begin
      step();
      check_model();
      // R4
      if (digit > 4'd9) check("R4 digit range", digit, 9);
      if (prev == 4'd9 && digit != 4'd9) begin
        check("R4 wrap to zero", digit, 0);
        saw_wrap = 1'b1;
      end
      prev = digit;
    end
    check("R4 wrap observed", saw_wrap, 1);
  endtask

  task automatic t_midrun_reset();
    // advance into the middle of a slow half-period
    repeat (F * S + F + 1) begin
      step();
      check_model();
    end
    @(negedge clk) rst = 1'b1;
    step();
    // R5
    check("R5 mid-run fast", fast_wave, 0);
    check("R5 mid-run slow", slow_wave, 0);
    check("R5 mid-run digit", digit, 0);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 4 * F * S; i++) begin
      step();
      check_model();
    end
  endtask

  initial begin
    t_reset_state();
    t_cadence();
    t_wrap();
    t_midrun_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule